// File: doc/BRIEF.md
# Real-Time Clock Alarm and Interrupt Register Block

This block is the register and interrupt side of a real-time clock. A separate time keeper does the counting and supplies the current time and date as BCD bytes, together with one-cycle rollover pulses for seconds, minutes, hours, days, months and years. This block shows that time and date on a small synchronous register bus and holds two programmable alarm times. It compares each alarm against the running hours, minutes and seconds.

Eight interrupt sources feed a sticky status register: the two alarm matches and the six rollover pulses. An enable register masks the status, and the masked bits are merged into one active-high interrupt request. Software clears a status bit by writing 1 to it. Every bus access completes in the clock cycle in which the select is low. A build parameter removes the read path of the configuration registers to save logic.

Top module: `rtc_irq_regs`

## Requirements
- R1: A write takes place on the rising clock edge where `reg_sel_n` = 0 and `reg_rd_wr_n` = 0. It stores `reg_wdata` into the register at `reg_addr`.
  - Address 3 holds alarm 0 as {minutes[15:8], seconds[7:0]}.
  - Address 4 holds alarm 1 in the same layout.
  - Address 5 holds the alarm hours as {alarm 1 hour[15:8], alarm 0 hour[7:0]}.
  - Address 6 holds the interrupt enables in bits [7:0].
  - Writes to addresses 0 to 2 have no effect.
- R2: A read takes place on the rising clock edge where `reg_sel_n` = 0 and `reg_rd_wr_n` = 1. After that edge, `reg_rdata` shows the value the addressed register held before the edge. In every cycle without a read, `reg_rdata` keeps its value.
- R3: The time registers are read-only and follow the time keeper inputs:
  - address 0 reads {minutes, seconds};
  - address 1 reads {day, hour};
  - address 2 reads {year, month}.
- R4: Alarm n sets status bit n once, on the edge where hour, minute and second first become equal to its programmed time. The bit is not set again while the equality lasts. The time in force during reset counts as already matched. Reprogramming an alarm to the current time counts as a new match.
- R5: A rollover pulse on `tk_roll[k]` sets status bit k+2. Bit 0 of `tk_roll` is seconds, then minutes, hours, day, month and year in that order.
- R6: Status bits (address 7, bits [7:0]) are sticky. Writing 1 to a status bit clears it and writing 0 leaves it alone. A set event arriving in the same cycle as a clear wins.
- R7: `irq_out` is high exactly when some status bit and its enable bit are both 1. It follows the registers in the same cycle.
- R8: With `READBACK` = 0, reads of addresses 3 to 6 return zero. The time and status registers still read normally, and the alarms and enables still act.
- R9: After reset, all alarm, enable and status registers are zero, `reg_rdata` is zero and `irq_out` is low.
- R10: Bits [15:8] of the enable and status registers read as zero whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel_n | input | 1 | Register access select, active low |
| reg_rd_wr_n | input | 1 | 1 = read, 0 = write |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| tk_sec | input | 8 | Current seconds, BCD |
| tk_min | input | 8 | Current minutes, BCD |
| tk_hour | input | 8 | Current hour, BCD, 24-hour |
| tk_day | input | 8 | Current day of month, BCD |
| tk_month | input | 8 | Current month, BCD |
| tk_year | input | 8 | Current year, BCD |
| tk_roll | input | 6 | One-cycle rollover pulses: sec, min, hour, day, month, year |
| irq_out | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that the time keeper drives `tk_roll` and the time fields from registers, so they are stable at the sampling edge. They also assume that reset is held long enough for the alarm comparators to see a defined time. The assertions check rollover-to-status setting, stickiness under writes of 0, read-data holding between reads, single-cycle alarm events and the zero read path. The stimulus sets all inputs on the falling edge. It draws times and alarm values from a narrow range of values so that alarm equalities, repeated matches and reprogramming onto the current time all occur often. It also sends W1C writes and rollover pulses in the same cycle.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 3;
  localparam int BCD_W     = 8;
  localparam int NUM_ALARM = 2;
  localparam int NUM_ROLL  = 6;
  localparam int NUM_SRC   = NUM_ALARM + NUM_ROLL;

  typedef enum logic [ADDR_W-1:0] {
    RA_TIME_MS = 3'd0,
    RA_TIME_DH = 3'd1,
    RA_DATE_YM = 3'd2,
    RA_ALM0_MS = 3'd3,
    RA_ALM1_MS = 3'd4,
    RA_ALM_HR  = 3'd5,
    RA_IRQ_EN  = 3'd6,
    RA_IRQ_ST  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic [BCD_W-1:0] hour;
    logic [BCD_W-1:0] min;
    logic [BCD_W-1:0] sec;
  } hms_t;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  hms_t now,
  input  hms_t target,
  output logic fire
);
  logic match_now;
  logic match_q;

  assign match_now = (now == target);

  // Starts as "already matched" so the reset time does not fire.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b1;
    else        match_q <= match_now;
  end

  assign fire = match_now & ~match_q;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_set,
  input  logic             en_we,
  input  logic             st_we,
  input  logic [SRC_W-1:0] wr_bits,
  output logic [SRC_W-1:0] en_q,
  output logic [SRC_W-1:0] st_q,
  output logic             irq
);
  logic [SRC_W-1:0] clr_mask;

  assign clr_mask = st_we ? wr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_we) en_q <= wr_bits;
      st_q <= (st_q & ~clr_mask) | src_set;
    end
  end

  assign irq = |(st_q & en_q);
endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
  import rtc_irq_pkg::*;
#(
  parameter bit READBACK = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sel_n,
  input  logic                         rd_wr_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  input  hms_t                         now,
  input  logic [BCD_W-1:0]             day,
  input  logic [BCD_W-1:0]             month,
  input  logic [BCD_W-1:0]             year,
  input  logic [NUM_SRC-1:0]           en_q,
  input  logic [NUM_SRC-1:0]           st_q,
  output hms_t [NUM_ALARM-1:0]         alm_tgt,
  output logic                         en_we,
  output logic                         st_we,
  output logic [NUM_SRC-1:0]           wr_bits
);
  logic wr_en, rd_en;
  logic [DATA_W-1:0] cfg_view;
  logic [DATA_W-1:0] rd_val;

  assign wr_en   = ~sel_n & ~rd_wr_n;
  assign rd_en   = ~sel_n &  rd_wr_n;
  assign en_we   = wr_en && (addr == RA_IRQ_EN);
  assign st_we   = wr_en && (addr == RA_IRQ_ST);
  assign wr_bits = wdata[NUM_SRC-1:0];

  for (genvar i = 0; i < NUM_ALARM; i++) begin : g_alm
    localparam logic [ADDR_W-1:0] MS_ADDR = ADDR_W'(RA_ALM0_MS + i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alm_tgt[i] <= '0;
      end else if (wr_en) begin
        if (addr == MS_ADDR) begin
          alm_tgt[i].min <= wdata[2*BCD_W-1:BCD_W];
          alm_tgt[i].sec <= wdata[BCD_W-1:0];
        end
        if (addr == RA_ALM_HR) alm_tgt[i].hour <= wdata[i*BCD_W +: BCD_W];
      end
    end
  end

  // Configuration read path, present only when readback is built in.
  if (READBACK) begin : g_rb
    always_comb begin
      cfg_view = '0;
      case (reg_addr_e'(addr))
        RA_ALM0_MS: cfg_view = {alm_tgt[0].min, alm_tgt[0].sec};
        RA_ALM1_MS: cfg_view = {alm_tgt[1].min, alm_tgt[1].sec};
        RA_ALM_HR:  cfg_view = {alm_tgt[1].hour, alm_tgt[0].hour};
        RA_IRQ_EN:  cfg_view[NUM_SRC-1:0] = en_q;
        default:    cfg_view = '0;
      endcase
    end
  end else begin : g_nrb
    assign cfg_view = '0;
  end

  always_comb begin
    rd_val = cfg_view;
    case (reg_addr_e'(addr))
      RA_TIME_MS: rd_val = {now.min, now.sec};
      RA_TIME_DH: rd_val = {day, now.hour};
      RA_DATE_YM: rd_val = {year, month};
      RA_IRQ_ST:  begin rd_val = '0; rd_val[NUM_SRC-1:0] = st_q; end
      default:    rd_val = cfg_view;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
  import rtc_irq_pkg::*;
#(
  parameter bit READBACK = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_sel_n,
  input  logic                reg_rd_wr_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [BCD_W-1:0]    tk_sec,
  input  logic [BCD_W-1:0]    tk_min,
  input  logic [BCD_W-1:0]    tk_hour,
  input  logic [BCD_W-1:0]    tk_day,
  input  logic [BCD_W-1:0]    tk_month,
  input  logic [BCD_W-1:0]    tk_year,
  input  logic [NUM_ROLL-1:0] tk_roll,
  output logic                irq_out
);
  hms_t                 now;
  hms_t [NUM_ALARM-1:0] alm_tgt;
  logic [NUM_ALARM-1:0] alm_fire;
  logic [NUM_SRC-1:0]   en_q, st_q, wr_bits, src_set;
  logic                 en_we, st_we;

  assign now     = '{hour: tk_hour, min: tk_min, sec: tk_sec};
  assign src_set = {tk_roll, alm_fire};

  rtc_bus_regs #(.READBACK(READBACK)) u_bus (
    .clk(clk), .rst_n(rst_n), .sel_n(reg_sel_n), .rd_wr_n(reg_rd_wr_n),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata), .now(now),
    .day(tk_day), .month(tk_month), .year(tk_year), .en_q(en_q), .st_q(st_q),
    .alm_tgt(alm_tgt), .en_we(en_we), .st_we(st_we), .wr_bits(wr_bits)
  );

  for (genvar i = 0; i < NUM_ALARM; i++) begin : g_cmp
    rtc_alarm_cmp u_cmp (
      .clk(clk), .rst_n(rst_n), .now(now), .target(alm_tgt[i]), .fire(alm_fire[i])
    );
  end

  rtc_irq_ctrl #(.SRC_W(NUM_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .en_we(en_we), .st_we(st_we),
    .wr_bits(wr_bits), .en_q(en_q), .st_q(st_q), .irq(irq_out)
  );
endmodule

// File: rtl/rtc_irq_regs_chk.sv
module rtc_irq_regs_chk
  import rtc_irq_pkg::*;
#(
  parameter bit READBACK = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_sel_n,
  input logic                reg_rd_wr_n,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic [NUM_ROLL-1:0] tk_roll,
  input logic                irq_out,
  input logic [NUM_SRC-1:0]  st_q,
  input logic [NUM_ALARM-1:0] alm_fire
);
  logic st_wr;
  assign st_wr = !reg_sel_n && !reg_rd_wr_n && (reg_addr == RA_IRQ_ST);

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel_n || !reg_rd_wr_n) |=> $stable(reg_rdata));

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == '0) |-> !irq_out);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_st
    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[k] && !(st_wr && reg_wdata[k])) |=> st_q[k]);
  end

  for (genvar k = 0; k < NUM_ROLL; k++) begin : g_roll
    // R5
    roll_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tk_roll[k] |=> st_q[NUM_ALARM+k]);
  end

  for (genvar i = 0; i < NUM_ALARM; i++) begin : g_alm
    // R4
    alarm_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alm_fire[i] |=> (!alm_fire[i] && st_q[i]));
  end

  if (!READBACK) begin : g_nrb
    // R8
    cfg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_sel_n && reg_rd_wr_n && reg_addr >= RA_ALM0_MS && reg_addr <= RA_IRQ_EN)
      |=> (reg_rdata == '0));
  end
endmodule

bind rtc_irq_regs rtc_irq_regs_chk #(.READBACK(READBACK)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel_n(reg_sel_n), .reg_rd_wr_n(reg_rd_wr_n),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .tk_roll(tk_roll), .irq_out(irq_out), .st_q(st_q), .alm_fire(alm_fire)
);

// File: tb/rtc_irq_regs_bench.sv
module rtc_irq_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel_n = 1'b1, reg_rd_wr_n = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata, rdata_nrb;
  logic [7:0]  tk_sec = '0, tk_min = '0, tk_hour = '0;
  logic [7:0]  tk_day = '0, tk_month = '0, tk_year = '0;
  logic [5:0]  tk_roll = '0;
  logic        irq_out, irq_nrb;

  int tests = 0, fails = 0;
  bit done = 0;

  // expected-state model
  logic [7:0]  m_ah [2], m_am [2], m_as [2];
  logic [7:0]  m_en = '0, m_st = '0;
  bit          m_prev [2];
  logic [15:0] m_rd = '0, m_rd_nrb = '0;

  always #4 clk = ~clk;

  rtc_irq_regs u_rtc_irq_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel_n(reg_sel_n), .reg_rd_wr_n(reg_rd_wr_n),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tk_sec(tk_sec), .tk_min(tk_min), .tk_hour(tk_hour), .tk_day(tk_day),
    .tk_month(tk_month), .tk_year(tk_year), .tk_roll(tk_roll), .irq_out(irq_out));

  rtc_irq_regs #(.READBACK(1'b0)) u_rtc_irq_regs_nrb (
    .clk(clk), .rst_n(rst_n), .reg_sel_n(reg_sel_n), .reg_rd_wr_n(reg_rd_wr_n),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_nrb),
    .tk_sec(tk_sec), .tk_min(tk_min), .tk_hour(tk_hour), .tk_day(tk_day),
    .tk_month(tk_month), .tk_year(tk_year), .tk_roll(tk_roll), .irq_out(irq_nrb));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] read_val(input logic [2:0] a, input bit rb);
    case (a)
      3'd0: return {tk_min, tk_sec};
      3'd1: return {tk_day, tk_hour};
      3'd2: return {tk_year, tk_month};
      3'd3: return rb ? {m_am[0], m_as[0]} : 16'h0;
      3'd4: return rb ? {m_am[1], m_as[1]} : 16'h0;
      3'd5: return rb ? {m_ah[1], m_ah[0]} : 16'h0;
      3'd6: return rb ? {8'h0, m_en} : 16'h0;
      default: return {8'h0, m_st};
    endcase
  endfunction

  function automatic string tag_for(input logic [2:0] a);
    if (a <= 3'd2) return "R3";
    if (a == 3'd7) return "R6";
    if (a == 3'd6) return "R10";
    return "R1";
  endfunction

  // One bus cycle: drive at the falling edge, update the model, check at the next falling edge.
  task automatic step(input bit sel, input bit rd, input logic [2:0] a, input logic [15:0] wd,
                      input logic [5:0] roll, input logic [7:0] h, input logic [7:0] mi,
                      input logic [7:0] s, input string tag);
    logic [1:0] fire;
    logic [7:0] clr;
    bit wr;
    reg_sel_n = !sel; reg_rd_wr_n = rd; reg_addr = a; reg_wdata = wd;
    tk_roll = roll; tk_hour = h; tk_min = mi; tk_sec = s;
    wr = sel && !rd;
    for (int i = 0; i < 2; i++) begin
      bit mt;
      mt = (h == m_ah[i]) && (mi == m_am[i]) && (s == m_as[i]);
      fire[i] = mt && !m_prev[i];
      m_prev[i] = mt;
    end
    if (sel && rd) begin
      m_rd = read_val(a, 1'b1);
      m_rd_nrb = read_val(a, 1'b0);
    end
    clr = (wr && a == 3'd7) ? wd[7:0] : 8'h0;
    m_st = (m_st & ~clr) | {roll, fire};
    if (wr) begin
      case (a)
        3'd3: begin m_am[0] = wd[15:8]; m_as[0] = wd[7:0]; end
        3'd4: begin m_am[1] = wd[15:8]; m_as[1] = wd[7:0]; end
        3'd5: begin m_ah[0] = wd[7:0]; m_ah[1] = wd[15:8]; end
        3'd6: m_en = wd[7:0];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check((tag == "") ? "R2" : tag, reg_rdata, m_rd);
    check((tag == "") ? "R8" : tag, rdata_nrb, m_rd_nrb);
    check((tag == "") ? "R7" : tag, {15'h0, irq_out}, {15'h0, |(m_st & m_en)});
  endtask

  task automatic rd_reg(input logic [2:0] a, input string tag);
    step(1, 1, a, 16'h0, 6'h0, tk_hour, tk_min, tk_sec, tag);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d, input string tag);
    step(1, 0, a, d, 6'h0, tk_hour, tk_min, tk_sec, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2; i++) begin
      m_ah[i] = '0; m_am[i] = '0; m_as[i] = '0; m_prev[i] = 1;
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", reg_rdata, 16'h0);
    check("R9", {15'h0, irq_out}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 3; a < 8; a++) begin
      rd_reg(3'(a), "R9");
      check("R9", reg_rdata, 16'h0);
    end

    // R3 time and date readback
    tk_day = 8'h28; tk_month = 8'h02; tk_year = 8'h24;
    step(1, 1, 3'd0, 16'h0, 6'h0, 8'h23, 8'h59, 8'h58, "R3");
    check("R3", reg_rdata, 16'h5958);
    rd_reg(3'd1, "R3"); check("R3", reg_rdata, 16'h2823);
    rd_reg(3'd2, "R3"); check("R3", reg_rdata, 16'h2402);

    // R10 upper enable bits read zero
    wr_reg(3'd6, 16'hFFFF, "R10");
    rd_reg(3'd6, "R10"); check("R10", reg_rdata, 16'h00FF);

    // R4 alarm 0 at 12:34:56 fires once
    wr_reg(3'd3, 16'h3456, "R1");
    wr_reg(3'd5, 16'h0712, "R1");
    wr_reg(3'd7, 16'hFFFF, "R6");
    step(0, 1, 3'd0, 16'h0, 6'h0, 8'h12, 8'h34, 8'h55, "R4");
    check("R4", {15'h0, irq_out}, 16'h0);
    step(0, 1, 3'd0, 16'h0, 6'h0, 8'h12, 8'h34, 8'h56, "R4");
    check("R4", {15'h0, irq_out}, 16'h1);
    wr_reg(3'd7, 16'h0001, "R6");
    repeat (3) step(0, 1, 3'd0, 16'h0, 6'h0, 8'h12, 8'h34, 8'h56, "R4");
    rd_reg(3'd7, "R4"); check("R4", reg_rdata, 16'h0000);

    // R5 each rollover pulse sets its own bit
    for (int k = 0; k < 6; k++) begin
      wr_reg(3'd7, 16'h00FF, "R5");
      step(0, 1, 3'd0, 16'h0, 6'(1 << k), 8'h01, 8'h00, 8'h00, "R5");
      rd_reg(3'd7, "R5"); check("R5", reg_rdata, 16'(1 << (k + 2)));
    end

    // R6 set wins over simultaneous clear
    step(1, 0, 3'd7, 16'h00FF, 6'h01, 8'h01, 8'h00, 8'h00, "R6");
    rd_reg(3'd7, "R6"); check("R6", reg_rdata, 16'h0004);

    // R8 configuration hidden when readback is off
    rd_reg(3'd3, "R8"); check("R8", rdata_nrb, 16'h0);
    rd_reg(3'd7, "R8"); check("R8", rdata_nrb, 16'h0004);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] a;
      logic [15:0] wd;
      bit sel, rd;
      sel = ($urandom_range(0, 3) != 0);
      rd  = $urandom_range(0, 1);
      a   = 3'($urandom_range(0, 7));
      wd  = 16'($urandom);
      if (a == 3'd3 || a == 3'd4) wd = {8'($urandom_range(0, 1)), 8'($urandom_range(0, 2))};
      if (a == 3'd5) wd = {8'($urandom_range(0, 1)), 8'($urandom_range(0, 1))};
      tk_day = 8'($urandom); tk_month = 8'($urandom); tk_year = 8'($urandom);
      step(sel, rd, a, wd, ($urandom_range(0, 5) == 0) ? 6'($urandom) : 6'h0,
           8'($urandom_range(0, 1)), 8'($urandom_range(0, 1)), 8'($urandom_range(0, 2)),
           (sel && rd) ? tag_for(a) : "");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule